// File: doc/BRIEF.md
# Latched-Address Static RAM Write Port

A small static memory model, 256 words of 4 bits, whose control pins are asynchronous, active-low and sampled by a fast internal clock. A cycle begins when the cycle strobe falls: at that point the address and a secondary select are captured into internal registers. The latched address is used for the rest of the cycle, so the address pins may change freely once it has been captured. A captured-high secondary select disables the whole cycle.

A write window is open while the strobe, the write line and the primary select are all low and the captured secondary select is low. The window closes on whichever of those three pins rises first. The data sampled last inside the window is then stored at the latched address. The write line may be held low across several consecutive strobe cycles, and each cycle then writes its own word.

Separate data-in and data-out ports are provided, with an output-enable flag so that the two can share one bus. The flag is low whenever the write line is low, whenever the primary select is high and whenever no enabled cycle is in progress. If the primary select stays low after the write line rises, the word just written is driven back out, which gives a read-modify-write cycle.

Top module: `latched_sram`

## Requirements
- R1: The address and the secondary select are captured when the strobe falls. Changes on the address pins later in the same cycle affect neither the stored word's location nor the read location.
- R2: A cycle that captured the secondary select high writes nothing, and `dout_en` stays 0 for the whole cycle.
- R3: A read cycle has the strobe and primary select low, the write line high and the secondary select captured low. It drives the word at the latched address on `dout` with `dout_en` = 1.
- R4: A write closes at the first rise of the strobe, the write line or the primary select, whichever comes first. Later rises in the same cycle cause no further write.
- R5: The data may change any number of times inside the write window. Only the last value held stable for two clocks before the closing edge is stored.
- R6: With the write line held low across consecutive strobe cycles, each cycle stores its own data at its own latched address.
- R7: `dout_en` is 0 while the write line is low, while the primary select is high, or while the strobe is high. `dout` is 0 whenever `dout_en` is 0.
- R8: When the write line rises while the strobe and primary select stay low, the just-written word appears on `dout` with `dout_en` = 1.
- R9: After a synchronous active-low reset, `dout_en` is 0 and every word reads 0.
- R10: Pins must be stable for two clocks. `dout_en` rises on the third rising clock edge after the strobe falls in a read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_n | input | 1 | Cycle strobe, active low; its fall latches the address and secondary select |
| wr_n | input | 1 | Write line, active low |
| sel_n | input | 1 | Primary select, active low, used live |
| sel2_n | input | 1 | Secondary select, active low, latched with the address |
| addr | input | 8 | Word address |
| din | input | 4 | Write data |
| dout | output | 4 | Read data, 0 when not enabled |
| dout_en | output | 1 | Output enable for the shared bus |

## Verification
Every pin passes through two sampling registers. The strobe's fall therefore reaches the address latch and `dout_en` on the third clock edge, while a select or write-line change reaches `dout_en` on the second edge. A commit lands one edge after the closing pin is seen. The bench changes inputs just after a falling clock edge and holds each phase for three clocks before sampling, so every result is settled when it is read. One read deliberately samples at two and three edges after the strobe falls, which pins the latency to exactly three edges. Stored words are checked through later read cycles against a reference array kept by the bench.

// File: rtl/latched_sram_pkg.sv
// Package: shared types for the latched-address static RAM.
// Assumes every control pin is active low and idles high.
package latched_sram_pkg;

    // Control pins as seen after the sampling registers.
    typedef struct packed {
        logic strobe_n;
        logic wr_n;
        logic sel_n;
        logic sel2_n;
    } ctrl_pins_t;

    localparam int CTRL_W = $bits(ctrl_pins_t);

endpackage

// File: rtl/pin_sync.sv
// Module: pin_sync
// Two-register sampler for asynchronous pins. The output is the pin value
// two clock edges late. Assumes each pin is stable for at least two clocks.
module pin_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o
);
    logic [W-1:0] stage_a;
    logic [W-1:0] stage_b;

    // Purpose: shift the raw pins through two sampling registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_a <= RST_VAL;
            stage_b <= RST_VAL;
        end else begin
            stage_a <= pin_i;
            stage_b <= stage_a;
        end
    end

    assign pin_o = stage_b;

endmodule

// File: rtl/cycle_ctrl.sv
// Module: cycle_ctrl
// Detects the strobe's fall, latches the address and secondary select, opens
// the write window and raises a one-cycle commit when the window closes.
// It also decides when read data may be driven. Inputs are already sampled.
module cycle_ctrl
    import latched_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_pins_t        pins,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] din_s,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              we,
    output logic [DATA_W-1:0] wdata,
    output logic              rd_en
);
    logic prev_strobe_n;
    logic strobe_fall;
    logic active;
    logic lat_en;
    logic window;
    logic window_q;
    logic [DATA_W-1:0] hold;

    assign strobe_fall = prev_strobe_n && !pins.strobe_n;

    // Purpose: remember the last sampled strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_strobe_n <= 1'b1;
        else        prev_strobe_n <= pins.strobe_n;
    end

    // Purpose: capture the address and secondary select at the strobe's fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_en   <= 1'b0;
            active   <= 1'b0;
        end else if (strobe_fall) begin
            lat_addr <= addr_s;
            lat_en   <= !pins.sel2_n;
            active   <= 1'b1;
        end else if (pins.strobe_n) begin
            active   <= 1'b0;
        end
    end

    assign window = active && lat_en && !pins.strobe_n && !pins.wr_n && !pins.sel_n;

    // Purpose: track the window and hold the latest data seen inside it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window_q <= 1'b0;
            hold     <= '0;
        end else begin
            window_q <= window;
            if (window) hold <= din_s;
        end
    end

    assign we    = window_q && !window;
    assign wdata = hold;
    assign rd_en = active && lat_en && !pins.strobe_n && !pins.sel_n && pins.wr_n;

    // R1: the address pins cannot move the latch inside a cycle.
    p_addr_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !pins.strobe_n) |=> $stable(lat_addr));

    // R4: a commit only follows a cycle in which the write line was low.
    p_commit_after_wr_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> $past(!pins.wr_n));

    // R2: a commit needs the secondary select to have been captured low.
    p_commit_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> lat_en);

endmodule

// File: rtl/sram_array.sv
// Module: sram_array
// Word array with one write port and one asynchronous read port. Resets to
// zero so that a read before any write is defined.
module sram_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Purpose: clear the array on reset, else store the committed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R8: a word written at the read location reads back on the next cycle.
    p_write_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == raddr) |=> (!$stable(raddr) || rdata == $past(wdata)));

endmodule

// File: rtl/latched_sram.sv
// Module: latched_sram (top)
// Static RAM with a latched address, a three-pin write window and an output
// enable that frees a shared bus during writes. The pins are asynchronous and
// are sampled on clk; each must stay stable for at least two clocks.
module latched_sram
    import latched_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic              wr_n,
    input  logic              sel_n,
    input  logic              sel2_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);
    localparam int BUS_W = ADDR_W + DATA_W;

    ctrl_pins_t        pins_s;
    logic [CTRL_W-1:0] pins_raw;
    logic [CTRL_W-1:0] pins_sync;
    logic [BUS_W-1:0]  bus_sync;
    logic [ADDR_W-1:0] lat_addr;
    logic              we;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;
    logic              rd_en;

    assign pins_raw = {strobe_n, wr_n, sel_n, sel2_n};

    pin_sync #(.W(CTRL_W), .RST_VAL({CTRL_W{1'b1}})) u_ctrl_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(pins_raw), .pin_o(pins_sync)
    );

    pin_sync #(.W(BUS_W), .RST_VAL({BUS_W{1'b0}})) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .pin_i({addr, din}), .pin_o(bus_sync)
    );

    assign pins_s = ctrl_pins_t'(pins_sync);

    cycle_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pins(pins_s),
        .addr_s(bus_sync[BUS_W-1:DATA_W]), .din_s(bus_sync[DATA_W-1:0]),
        .lat_addr(lat_addr), .we(we), .wdata(wdata), .rd_en(rd_en)
    );

    sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(lat_addr),
        .wdata(wdata), .raddr(lat_addr), .rdata(rdata)
    );

    assign dout_en = rd_en;
    assign dout    = rd_en ? rdata : '0;

    // R7: no drive while the sampled write line is low.
    p_oe_off_in_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> pins_s.wr_n);

    // R7: no drive while the primary select or the strobe is high.
    p_oe_needs_select_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> (!pins_s.sel_n && !pins_s.strobe_n));

    // R7: the data output is quiet whenever it is not enabled.
    p_dout_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

endmodule

// File: tb/test_latched_sram.sv
module test_latched_sram;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       e = 1'b1, w = 1'b1, s1 = 1'b1, s2 = 1'b1;
    logic [7:0] a = '0;
    logic [3:0] d = '0;
    logic [3:0] dout;
    logic       dout_en;

    int total = 0;
    int bad = 0;
    logic [3:0] ref_mem [256];

    always #5 clk = ~clk;

    latched_sram i_latched_sram (
        .clk(clk), .rst_n(rst_n), .strobe_n(e), .wr_n(w), .sel_n(s1),
        .sel2_n(s2), .addr(a), .din(d), .dout(dout), .dout_en(dout_en)
    );

    task automatic hold(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] expect_word(logic [7:0] adr);
        return ref_mem[adr];
    endfunction

    // term: 0 strobe rises first, 1 write line, 2 primary select
    task automatic wr_cycle(logic [7:0] adr, logic [3:0] dat, int term, logic s2v);
        e = 1; w = 1; s1 = 1; a = adr; s2 = s2v; hold(3);
        e = 0; hold(3);
        a = ~adr; s2 = ~s2v;            // R1: pins move after the latch
        s1 = 0; hold(3);
        if (s2v) chk("R2 oe in disabled cycle", dout_en, 0);
        w = 0; d = ~dat; hold(3);
        chk("R7 oe while write low", dout_en, 0);
        d = dat ^ 4'h5; hold(3);        // R5: several values in the window
        d = dat; hold(3);
        case (term)
            0: e = 1;
            1: w = 1;
            default: s1 = 1;
        endcase
        hold(3);
        if (term == 1 && !s2v) begin
            chk("R8 rmw enable", dout_en, 1);
            chk("R8 rmw data", dout, dat);
        end
        d = ~dat; hold(3);              // R4: later edges must not write
        e = 1; w = 1; s1 = 1; hold(3);
        if (!s2v) ref_mem[adr] = dat;
    endtask

    task automatic rd_cycle(logic [7:0] adr, bit lat, logic s2v);
        e = 1; w = 1; s1 = 0; s2 = s2v; a = adr; hold(3);
        e = 0;
        if (lat) begin
            hold(2); chk("R10 oe not before third edge", dout_en, 0);
            hold(1); chk("R10 oe at third edge", dout_en, 1);
        end
        hold(3);
        a = adr + 8'd1;
        hold(3);
        if (s2v) begin
            chk("R2 oe in disabled read", dout_en, 0);
        end else begin
            chk("R3 read enable", dout_en, 1);
            chk("R3 R1 read data", dout, expect_word(adr));
        end
        s1 = 1; hold(3);
        chk("R7 oe with select high", dout_en, 0);
        chk("R7 dout quiet", dout, 0);
        e = 1; hold(3);
    endtask

    initial begin
        void'($urandom(32'd1207));
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        hold(4);
        chk("R9 oe after reset", dout_en, 0);
        rst_n = 1'b1;
        hold(2);
        rd_cycle(8'h00, 1, 0);
        rd_cycle(8'hFF, 0, 0);

        // Directed: each terminating pin
        wr_cycle(8'h10, 4'hA, 0, 0);
        wr_cycle(8'h11, 4'h3, 1, 0);
        wr_cycle(8'h12, 4'hC, 2, 0);
        rd_cycle(8'h10, 0, 0);
        rd_cycle(8'h11, 0, 0);
        rd_cycle(8'h12, 1, 0);
        chk("R4 strobe-closed word", ref_mem[8'h10], 4'hA);

        // R2: disabled cycle leaves the word alone
        wr_cycle(8'h10, 4'h6, 1, 1);
        rd_cycle(8'h10, 0, 1);
        rd_cycle(8'h10, 0, 0);

        // R6: write line held low across consecutive cycles
        w = 0; s1 = 0; s2 = 0;
        for (int k = 0; k < 4; k++) begin
            a = 8'h40 + 8'(k); e = 1; hold(3);
            e = 0; hold(3);
            d = 4'(k * 3 + 1); hold(3);
            chk("R6 oe held write", dout_en, 0);
            e = 1; hold(3);
            ref_mem[8'h40 + 8'(k)] = 4'(k * 3 + 1);
        end
        w = 1; s1 = 1; hold(3);
        for (int k = 0; k < 4; k++) rd_cycle(8'h40 + 8'(k), 0, 0);

        // Random writes and reads
        for (int k = 0; k < 40; k++) begin
            wr_cycle(8'($urandom), 4'($urandom), int'($urandom % 3),
                     ($urandom % 4) == 0);
        end
        for (int k = 0; k < 40; k++) rd_cycle(8'($urandom), 0, 0);
        for (int k = 0; k < 40; k++) rd_cycle(8'h10 + 8'(k), 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule